// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transceiver

This block sends and receives characters on a pair of asynchronous serial lines, in both directions at once. The host hands it one byte at a time to transmit through a valid/ready stream and takes received characters from a second valid/ready stream. A set of plain configuration pins selects the character format. The data field is 5 to 8 bits long. A parity bit is optional and may be odd or even. A character ends with one or two stop bits. The transmitter captures the format when a character starts. The receiver captures it when it confirms a start bit. Changing the pins therefore never disturbs a character that is already on the line.

Each direction has its own bit-rate enable, so the two directions can run at unrelated rates from the same system clock. The transmitter moves one bit per pulse of its enable. The receiver takes sixteen pulses of its enable per bit. It uses them to find the midpoint of the start bit, to reject short noise pulses and to sample each later bit in its centre. Each received character carries a parity-error flag and a framing-error flag. A sticky overrun flag reports a character that replaced one the host had not yet taken.

Stream rules. On transmit, a byte is accepted on a clock edge where `tx_valid` and `tx_ready` are both high. `tx_ready` is high exactly when the one-byte holding register is empty, and the host may hold `tx_valid` high for as long as it likes. On receive, `rx_valid` stays high and `rx_data` and the flags stay stable until a clock edge with `rx_ready` high. The receiver cannot be stalled by back-pressure. If a new character completes while the previous one is still unread, the new one replaces it and the overrun flag is raised.

Top module: `serial_xcvr`

## Requirements
- R1: After reset `txd` is 1, `tx_ready` is 1 and `rx_valid` is 0. `txd` returns to 1 and stays there whenever no character is being sent.
- R2: A transmitted character starts with one bit of 0. It then sends 5 + `cfg_len` data bits, least significant first. Each bit lasts exactly one `tx_tick` period, and data bits above the selected length are not sent.
- R3: When `cfg_par_en` is 1, a parity bit follows the data bits. With `cfg_par_odd` = 0 the number of ones in data plus parity is even; with `cfg_par_odd` = 1 it is odd.
- R4: The character ends with one stop bit of 1, or with two when `cfg_stop2` is 1.
- R5: A byte waiting in the holding register starts the next character in the bit period right after the last stop bit. The holding register empties when a character starts, so `tx_ready` rises again while that character is still being sent.
- R6: The receiver reads a character framed as in R2 to R4 at sixteen `rx_tick16` pulses per bit. It presents the data right-aligned on `rx_data`, with the bits above the selected length at 0.
- R7: A low pulse on `rxd` shorter than half a bit is not taken as a start bit and produces no character.
- R8: `rx_par_err` is 1 with a character whose received parity bit does not match the selected parity, and 0 otherwise.
- R9: `rx_frame_err` is 1 with a character whose first stop-bit sample is 0. After such a character the receiver waits for `rxd` to return to 1 before it looks for the next start bit.
- R10: `rx_valid` stays high until a handshake with `rx_ready`, which clears it. A character that completes while `rx_valid` is high and not being read sets `rx_overrun` and replaces `rx_data`. A handshake clears `rx_overrun`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_len | input | 2 | Data length code: 5 + value bits |
| cfg_par_en | input | 1 | Add or check a parity bit |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 even |
| cfg_stop2 | input | 1 | Transmit two stop bits |
| tx_tick | input | 1 | Transmit bit-rate enable, one pulse per bit |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Holding register empty |
| tx_data | input | 8 | Transmit byte |
| txd | output | 1 | Serial transmit line |
| rx_tick16 | input | 1 | Receive enable, sixteen pulses per bit |
| rxd | input | 1 | Serial receive line (asynchronous) |
| rx_valid | output | 1 | Received character available |
| rx_ready | input | 1 | Host takes the character |
| rx_data | output | 8 | Received data, right-aligned |
| rx_par_err | output | 1 | Parity mismatch on this character |
| rx_frame_err | output | 1 | Stop bit sampled as 0 |
| rx_overrun | output | 1 | An unread character was replaced |

## Verification
The assertions take for granted that `tx_tick` and `rx_tick16` are single-cycle pulses and that `rxd` changes no faster than one sixteenth of a bit. They also assume the configuration pins move only while both directions are idle, or at least that they do not move during the cycle that captures them. The stimulus meets these conditions. It produces both enables from fixed dividers, holds each serial bit for exactly sixteen receive pulses, and changes the configuration only between characters. Back-pressure is tested by leaving `rx_ready` low across two whole characters.

// File: rtl/sxc_pkg.sv
package sxc_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_START,
    PH_DATA,
    PH_PAR,
    PH_STOP,
    PH_STOP2,
    PH_BRK
  } phase_e;

  typedef struct packed {
    logic [1:0] len;
    logic       par_en;
    logic       par_odd;
    logic       stop2;
  } frame_cfg_t;

endpackage

// File: rtl/sxc_sync.sv
module sxc_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= RESET_VAL;
        else if (i == 0) chain[i] <= d;
        else chain[i] <= chain[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/sxc_tx.sv
module sxc_tx
  import sxc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  frame_cfg_t        cfg,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              txd
);
  localparam int BIT_W    = $clog2(DATA_W + 1);
  localparam int MIN_BITS = DATA_W - 3;

  phase_e            ph;
  frame_cfg_t        cfg_q;
  logic [DATA_W-1:0] hold_q, sh_q;
  logic              hold_full, par_q, txd_q;
  logic [BIT_W-1:0]  bit_cnt, last_idx;
  logic              frame_end, start_now;

  assign last_idx  = BIT_W'(MIN_BITS - 1) + BIT_W'(cfg_q.len);
  assign frame_end = tick && ((ph == PH_STOP && !cfg_q.stop2) || ph == PH_STOP2);
  assign start_now = tick && hold_full && (ph == PH_IDLE || frame_end);
  assign in_ready  = !hold_full;
  assign txd       = txd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph        <= PH_IDLE;
      cfg_q     <= '0;
      hold_q    <= '0;
      sh_q      <= '0;
      hold_full <= 1'b0;
      par_q     <= 1'b0;
      txd_q     <= 1'b1;
      bit_cnt   <= '0;
    end else begin
      if (in_valid && !hold_full) begin
        hold_q    <= in_data;
        hold_full <= 1'b1;
      end
      if (start_now) begin
        sh_q      <= hold_q;
        cfg_q     <= cfg;
        hold_full <= 1'b0;
        par_q     <= 1'b0;
        txd_q     <= 1'b0;
        ph        <= PH_START;
      end else if (tick) begin
        case (ph)
          PH_START: begin
            txd_q   <= sh_q[0];
            par_q   <= sh_q[0];
            sh_q    <= sh_q >> 1;
            bit_cnt <= '0;
            ph      <= PH_DATA;
          end
          PH_DATA: begin
            if (bit_cnt == last_idx) begin
              if (cfg_q.par_en) begin
                txd_q <= par_q ^ cfg_q.par_odd;
                ph    <= PH_PAR;
              end else begin
                txd_q <= 1'b1;
                ph    <= PH_STOP;
              end
            end else begin
              txd_q   <= sh_q[0];
              par_q   <= par_q ^ sh_q[0];
              sh_q    <= sh_q >> 1;
              bit_cnt <= bit_cnt + 1'b1;
            end
          end
          PH_PAR: begin
            txd_q <= 1'b1;
            ph    <= PH_STOP;
          end
          PH_STOP: begin
            txd_q <= 1'b1;
            ph    <= cfg_q.stop2 ? PH_STOP2 : PH_IDLE;
          end
          PH_STOP2: begin
            txd_q <= 1'b1;
            ph    <= PH_IDLE;
          end
          default: begin
            txd_q <= 1'b1;
            ph    <= PH_IDLE;
          end
        endcase
      end
    end
  end

  a_r1_idle_line: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_IDLE) |-> txd);
  a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_START) |-> !txd);
  a_r4_stop_high: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_STOP || ph == PH_STOP2) |-> txd);
  a_r5_accept_fills: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);
  a_r5_start_frees: assert property (@(posedge clk) disable iff (!rst_n)
    start_now |=> (in_ready && !txd));
endmodule

// File: rtl/sxc_rx.sv
module sxc_rx
  import sxc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick16,
  input  logic              rxd_s,
  input  logic [1:0]        cfg_len,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              par_err,
  output logic              frame_err,
  output logic              overrun
);
  localparam int CNT_W    = $clog2(OSR);
  localparam int BIT_W    = $clog2(DATA_W + 1);
  localparam int MIN_BITS = DATA_W - 3;
  localparam logic [CNT_W-1:0] MID  = CNT_W'(OSR/2 - 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OSR - 1);

  phase_e            ph;
  logic [CNT_W-1:0]  cnt;
  logic [BIT_W-1:0]  bit_cnt, last_idx;
  logic [DATA_W-1:0] sh_q;
  logic [1:0]        len_q;
  logic              pen_q, podd_q, par_acc, pe_q;
  logic              smp, fin;
  logic [BIT_W-1:0]  rshift;

  assign last_idx = BIT_W'(MIN_BITS - 1) + BIT_W'(len_q);
  assign rshift   = BIT_W'(3) - BIT_W'(len_q);
  assign smp      = tick16 && (cnt == LAST);
  assign fin      = smp && (ph == PH_STOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph        <= PH_IDLE;
      cnt       <= '0;
      bit_cnt   <= '0;
      sh_q      <= '0;
      len_q     <= '0;
      pen_q     <= 1'b0;
      podd_q    <= 1'b0;
      par_acc   <= 1'b0;
      pe_q      <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
      par_err   <= 1'b0;
      frame_err <= 1'b0;
      overrun   <= 1'b0;
    end else begin
      if (out_valid && out_ready) begin
        out_valid <= 1'b0;
        overrun   <= 1'b0;
      end
      if (fin) begin
        out_valid <= 1'b1;
        out_data  <= sh_q >> rshift;
        par_err   <= pe_q;
        frame_err <= !rxd_s;
        overrun   <= out_valid && !out_ready;
      end
      if (ph == PH_BRK) begin
        if (rxd_s) ph <= PH_IDLE;
      end else if (tick16) begin
        case (ph)
          PH_IDLE: begin
            if (!rxd_s) begin
              ph  <= PH_START;
              cnt <= '0;
            end
          end
          PH_START: begin
            if (cnt == MID) begin
              cnt <= '0;
              if (!rxd_s) begin
                ph      <= PH_DATA;
                bit_cnt <= '0;
                par_acc <= 1'b0;
                pe_q    <= 1'b0;
                len_q   <= cfg_len;
                pen_q   <= cfg_par_en;
                podd_q  <= cfg_par_odd;
              end else begin
                ph <= PH_IDLE;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          PH_DATA: begin
            cnt <= cnt + 1'b1;
            if (cnt == LAST) begin
              cnt     <= '0;
              sh_q    <= {rxd_s, sh_q[DATA_W-1:1]};
              par_acc <= par_acc ^ rxd_s;
              if (bit_cnt == last_idx) ph <= pen_q ? PH_PAR : PH_STOP;
              else bit_cnt <= bit_cnt + 1'b1;
            end
          end
          PH_PAR: begin
            cnt <= cnt + 1'b1;
            if (cnt == LAST) begin
              cnt  <= '0;
              pe_q <= (rxd_s != (par_acc ^ podd_q));
              ph   <= PH_STOP;
            end
          end
          PH_STOP: begin
            cnt <= cnt + 1'b1;
            if (cnt == LAST) begin
              cnt <= '0;
              ph  <= rxd_s ? PH_IDLE : PH_BRK;
            end
          end
          default: ph <= PH_IDLE;
        endcase
      end
    end
  end

  a_r10_hold_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid);
  a_r10_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && out_valid && !out_ready) |=> overrun);
  a_r10_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !fin) |=> (!out_valid && !overrun));
  a_r10_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !fin) |=> $stable(out_data));
  a_r9_break_waits: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_BRK && !rxd_s) |=> (ph == PH_BRK));
endmodule

// File: rtl/serial_xcvr.sv
module serial_xcvr
  import sxc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_len,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_stop2,
  input  logic              tx_tick,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] tx_data,
  output logic              txd,
  input  logic              rx_tick16,
  input  logic              rxd,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_par_err,
  output logic              rx_frame_err,
  output logic              rx_overrun
);
  frame_cfg_t cfg;
  logic       rxd_s;

  assign cfg = '{len: cfg_len, par_en: cfg_par_en, par_odd: cfg_par_odd, stop2: cfg_stop2};

  sxc_tx #(.DATA_W(DATA_W)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tx_tick),
    .cfg      (cfg),
    .in_valid (tx_valid),
    .in_data  (tx_data),
    .in_ready (tx_ready),
    .txd      (txd)
  );

  sxc_sync #(.STAGES(SYNC_N), .RESET_VAL(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (rxd),
    .q     (rxd_s)
  );

  sxc_rx #(.DATA_W(DATA_W), .OSR(OSR)) u_rx (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick16      (rx_tick16),
    .rxd_s       (rxd_s),
    .cfg_len     (cfg_len),
    .cfg_par_en  (cfg_par_en),
    .cfg_par_odd (cfg_par_odd),
    .out_ready   (rx_ready),
    .out_valid   (rx_valid),
    .out_data    (rx_data),
    .par_err     (rx_par_err),
    .frame_err   (rx_frame_err),
    .overrun     (rx_overrun)
  );
endmodule

// File: tb/serial_xcvr_bench.sv
module serial_xcvr_bench;
  localparam int TXP = 8;
  localparam int RXT = 2;
  localparam int RXB = 16 * RXT;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] cfg_len = 2'd3;
  logic       cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_stop2 = 1'b0;
  logic       tx_tick = 1'b0, tx_valid = 1'b0, rx_tick16 = 1'b0, rxd = 1'b1, rx_ready = 1'b0;
  logic [7:0] tx_data = '0;
  logic       tx_ready, txd, rx_valid, rx_par_err, rx_frame_err, rx_overrun;
  logic [7:0] rx_data;
  int checks = 0, errors = 0;
  longint cyc = 0;

  serial_xcvr u_serial_xcvr (
    .clk(clk), .rst_n(rst_n), .cfg_len(cfg_len), .cfg_par_en(cfg_par_en),
    .cfg_par_odd(cfg_par_odd), .cfg_stop2(cfg_stop2), .tx_tick(tx_tick),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .txd(txd),
    .rx_tick16(rx_tick16), .rxd(rxd), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .rx_par_err(rx_par_err), .rx_frame_err(rx_frame_err),
    .rx_overrun(rx_overrun)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    int tc = 0, rc = 0;
    forever begin
      @(negedge clk);
      tx_tick   = (tc == TXP - 1);
      rx_tick16 = (rc == RXT - 1);
      tc = (tc + 1) % TXP;
      rc = (rc + 1) % RXT;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_cfg(logic [1:0] len, logic pen, logic podd, logic s2);
    @(negedge clk);
    cfg_len = len; cfg_par_en = pen; cfg_par_odd = podd; cfg_stop2 = s2;
  endtask

  function automatic logic [15:0] mk_frame(logic [7:0] d, int nd, logic pen,
                                           logic podd, logic s2, output int n);
    logic [15:0] f;
    logic p;
    int k;
    f = '1; f[0] = 1'b0; p = 1'b0;
    for (int i = 0; i < nd; i++) begin f[1+i] = d[i]; p ^= d[i]; end
    k = 1 + nd;
    if (pen) begin f[k] = p ^ podd; k++; end
    f[k] = 1'b1; k++;
    if (s2) begin f[k] = 1'b1; k++; end
    n = k;
    return f;
  endfunction

  task automatic tx_send(logic [7:0] d);
    @(negedge clk);
    tx_valid = 1'b1; tx_data = d;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic tx_capture(int n, output logic [15:0] got, output longint t0);
    int guard = 0;
    got = '1;
    @(negedge clk);
    while (txd !== 1'b0 && guard < 2000) begin @(negedge clk); guard++; end
    t0 = cyc;
    repeat (TXP/2) @(negedge clk);
    got[0] = txd;
    for (int i = 1; i < n; i++) begin
      repeat (TXP) @(negedge clk);
      got[i] = txd;
    end
  endtask

  task automatic tx_case(string req, logic [7:0] d, logic [1:0] len, logic pen,
                         logic podd, logic s2);
    logic [15:0] exp, got, mask;
    longint t0;
    int n;
    set_cfg(len, pen, podd, s2);
    exp = mk_frame(d, 5 + int'(len), pen, podd, s2, n);
    mask = 16'((32'h1 << n) - 1);
    fork
      tx_send(d);
      tx_capture(n, got, t0);
    join
    check(req, 32'(got & mask), 32'(exp & mask));
    repeat (2 * TXP) @(negedge clk);
    check("R1 line idle after frame", 32'(txd), 32'd1);
  endtask

  task automatic rx_bit(logic v);
    rxd = v;
    repeat (RXB) @(negedge clk);
  endtask

  task automatic rx_send(logic [7:0] d, int nd, logic pen, logic podd, logic s2,
                         logic bad_par, logic bad_stop);
    logic p = 1'b0;
    @(negedge clk);
    rx_bit(1'b0);
    for (int i = 0; i < nd; i++) begin rx_bit(d[i]); p ^= d[i]; end
    if (pen) rx_bit(p ^ podd ^ bad_par);
    rx_bit(!bad_stop);
    if (s2) rx_bit(1'b1);
    rxd = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic rx_read();
    @(negedge clk); rx_ready = 1'b1;
    @(negedge clk); rx_ready = 1'b0;
  endtask

  task automatic rx_expect(string req, logic [7:0] d, logic pe, logic fe, logic ov);
    check({req, " valid"}, 32'(rx_valid), 32'd1);
    check({req, " data"}, 32'(rx_data), 32'(d));
    check({req, " flags"}, {29'd0, rx_par_err, rx_frame_err, rx_overrun}, {29'd0, pe, fe, ov});
  endtask

  task automatic t_reset();
    check("R1 reset txd", 32'(txd), 32'd1);
    check("R1 reset tx_ready", 32'(tx_ready), 32'd1);
    check("R1 reset rx_valid", 32'(rx_valid), 32'd0);
  endtask

  task automatic t_tx_formats();
    tx_case("R2 R4 8 bits no parity 1 stop", 8'hA5, 2'd3, 1'b0, 1'b0, 1'b0);
    tx_case("R2 R3 R4 5 bits even 2 stop", 8'hFB, 2'd0, 1'b1, 1'b0, 1'b1);
    tx_case("R3 7 bits odd", 8'h35, 2'd2, 1'b1, 1'b1, 1'b0);
    tx_case("R3 6 bits even", 8'h2D, 2'd1, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_tx_back_to_back();
    logic [15:0] ga, gb, ea, eb;
    longint ta, tb;
    int n;
    set_cfg(2'd3, 1'b0, 1'b0, 1'b0);
    ea = mk_frame(8'h3C, 8, 1'b0, 1'b0, 1'b0, n);
    eb = mk_frame(8'hC3, 8, 1'b0, 1'b0, 1'b0, n);
    fork
      begin tx_send(8'h3C); tx_send(8'hC3); end
      begin tx_capture(n, ga, ta); tx_capture(n, gb, tb); end
    join
    check("R5 first frame", 32'(ga[9:0]), 32'(ea[9:0]));
    check("R5 second frame", 32'(gb[9:0]), 32'(eb[9:0]));
    check("R5 no gap between frames", 32'(tb - ta), 32'(n * TXP));
    check("R5 ready while idle", 32'(tx_ready), 32'd1);
  endtask

  task automatic t_rx_basic();
    set_cfg(2'd3, 1'b0, 1'b0, 1'b0);
    rx_send(8'h96, 8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    rx_expect("R6 8N1", 8'h96, 1'b0, 1'b0, 1'b0);
    rx_read();
    @(negedge clk);
    check("R10 read clears valid", 32'(rx_valid), 32'd0);
    set_cfg(2'd1, 1'b1, 1'b0, 1'b1);
    rx_send(8'h2D, 6, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    rx_expect("R6 6 bits even right aligned", 8'h2D, 1'b0, 1'b0, 1'b0);
    rx_read();
  endtask

  task automatic t_rx_parity();
    set_cfg(2'd2, 1'b1, 1'b1, 1'b0);
    rx_send(8'h55, 7, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    rx_expect("R8 bad odd parity", 8'h55, 1'b1, 1'b0, 1'b0);
    rx_read();
    rx_send(8'h55, 7, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    rx_expect("R8 good odd parity", 8'h55, 1'b0, 1'b0, 1'b0);
    rx_read();
  endtask

  task automatic t_rx_framing();
    set_cfg(2'd3, 1'b0, 1'b0, 1'b0);
    rx_send(8'h81, 8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    rx_expect("R9 stop sampled low", 8'h81, 1'b0, 1'b1, 1'b0);
    rx_read();
    rx_send(8'h7E, 8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    rx_expect("R9 recovery after break", 8'h7E, 1'b0, 1'b0, 1'b0);
    rx_read();
  endtask

  task automatic t_rx_glitch();
    @(negedge clk);
    rxd = 1'b0;
    repeat (RXB/4) @(negedge clk);
    rxd = 1'b1;
    repeat (12 * RXB) @(negedge clk);
    check("R7 short low pulse ignored", 32'(rx_valid), 32'd0);
  endtask

  task automatic t_rx_overrun();
    set_cfg(2'd3, 1'b0, 1'b0, 1'b0);
    rx_send(8'h11, 8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R10 held without read", 32'(rx_data), 32'h11);
    rx_send(8'h22, 8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    rx_expect("R10 overrun replaces", 8'h22, 1'b0, 1'b0, 1'b1);
    rx_read();
    @(negedge clk);
    check("R10 read clears overrun", {30'd0, rx_valid, rx_overrun}, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_tx_formats();
    t_tx_back_to_back();
    t_rx_basic();
    t_rx_parity();
    t_rx_framing();
    t_rx_glitch();
    t_rx_overrun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule